// File: doc/BRIEF.md
# Selectable-Order Noise-Shaping Fractional Divide Generator

This block produces, once per phase-detector reference cycle, the integer divide value that a fractional-N feedback divider should use next. The value is a programmed integer part plus a small signed correction from a cascade of up to four first-order accumulators whose carries are recombined by backward differencing. The cascade wraps at a programmable modulus anywhere from 1 to 2^32 − 1, so over time the mean divide ratio equals the integer part plus the numerator over that modulus.

Software presents the integer part, numerator, modulus and order on the inputs and pulses `load`. That pulse copies the settings into internal registers and clears every accumulator and difference register. After that, each cycle with `enable` high advances the modulator by one step and delivers one registered divide value with a valid strobe. A numerator that is zero gives plain integer division. A numerator that is not below the modulus is rejected: the fractional path stays at zero and an error flag is raised.

Top module: `mash_frac_divider`

## Requirements
- R1: While `rst` is high at a clock edge, that edge clears `divOut` to 0, `divValid` to 0 and `cfgErr` to 0.
- R2: New values on `intIn`, `numIn`, `denIn` and `orderSel` have no effect until a clock edge with `load` high. That edge captures them, clears all accumulators and difference history, and drops `divValid` to 0 for that cycle.
- R3: With order 1 (`orderSel` = 0), the sum of the outputs over k·den steps that start right after a load equals int·k·den + num·k exactly.
- R4: Stage 1 adds the numerator to its residue. Each stage k > 1 adds the residue that stage k−1 produced in the same step. A stage whose sum is at least the modulus subtracts the modulus and emits carry 1; otherwise it emits 0. The output is c1 + Δc2 + Δ²c3 + Δ³c4, where Δ is the backward difference over steps, history before the load counts as 0, and carries of stages above the order `orderSel`+1 are taken as 0.
- R5: When the captured numerator is 0, every valid output equals the captured integer part.
- R6: When the captured numerator is greater than or equal to the captured modulus (a modulus of 0 included), `cfgErr` reads 1 from the cycle after the load, and every valid output equals the integer part.
- R7: A cycle with `enable` low and `load` low leaves `divValid` at 0 and `divOut` unchanged, and the modulator state is held. The sequence then resumes exactly where it stopped.
- R8: `divOut` is a 14-bit two's-complement value. Results from −7 (integer part 0) up to 4103 (integer part 4095) appear without wrap-around.
- R9: Each clock edge with `enable` high and `load` low produces a new value, with `divValid` reading 1 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference-rate clock |
| rst | input | 1 | Synchronous reset, active high |
| load | input | 1 | Capture settings and clear modulator state |
| enable | input | 1 | Advance the modulator by one step this cycle |
| intIn | input | 12 | Integer part of the divide ratio |
| numIn | input | 32 | Fraction numerator |
| denIn | input | 32 | Fraction modulus (denominator) |
| orderSel | input | 2 | Modulator order minus one (0 → order 1, 3 → order 4) |
| divOut | output | 14 | Signed instantaneous divide value |
| divValid | output | 1 | `divOut` was updated on the last edge |
| cfgErr | output | 1 | Captured numerator is not below the modulus |

## Verification
Several properties are checked on every cycle by the assertions. The correction always stays within −7..+8. Each residue stays below the modulus. A rejected setting forces a zero correction, and a zero numerator forces the output to the integer part. Idle cycles leave the state frozen, a load clears it, and a valid strobe follows each step. Other behaviour can only be shown by the bench's scenarios, which compare every output against an independent model: the exact averaging over whole modulus periods, the exact carry-differencing sequence for each order, the extreme integer parts, and resumption after a pause.

// File: rtl/mash_pkg.sv
package mash_pkg;

  // Strobes sent from the control unit to the datapath each cycle.
  typedef struct packed {
    logic clr;      // clear accumulators and difference history
    logic step;     // advance one modulator step and register output
    logic fracOff;  // rejected setting: hold fractional path at zero
  } mash_strb_t;

endpackage

// File: rtl/mash_ctrl.sv
module mash_ctrl
  import mash_pkg::*;
#(
  parameter int INT_W  = 12,
  parameter int FRAC_W = 32,
  parameter int ORD_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              enable,
  input  logic [INT_W-1:0]  intIn,
  input  logic [FRAC_W-1:0] numIn,
  input  logic [FRAC_W-1:0] denIn,
  input  logic [ORD_W-1:0]  orderSel,
  output logic [INT_W-1:0]  cfgInt,
  output logic [FRAC_W-1:0] cfgNum,
  output logic [FRAC_W-1:0] cfgDen,
  output logic [ORD_W-1:0]  cfgOrd,
  output logic              cfgErr,
  output mash_strb_t        strb
);

  // Shadow copies of the settings, updated only by a load.
  always_ff @(posedge clk) begin
    if (rst) begin
      cfgInt <= '0;
      cfgNum <= '0;
      cfgDen <= FRAC_W'(1);
      cfgOrd <= '0;
      cfgErr <= 1'b0;
    end else if (load) begin
      cfgInt <= intIn;
      cfgNum <= numIn;
      cfgDen <= denIn;
      cfgOrd <= orderSel;
      cfgErr <= (numIn >= denIn);
    end
  end

  // Load has priority over stepping.
  always_comb begin
    strb.clr     = load;
    strb.step    = enable & ~load;
    strb.fracOff = cfgErr;
  end

  // R6: a load flags a numerator that is not below the modulus
  a_r6_err_capture: assert property (@(posedge clk) disable iff (rst)
    load |=> (cfgErr == ($past(numIn) >= $past(denIn))));

  // R2: settings never move without a load
  a_r2_cfg_hold: assert property (@(posedge clk) disable iff (rst)
    !load |=> ($stable(cfgNum) && $stable(cfgDen) && $stable(cfgInt) && $stable(cfgOrd)));

endmodule

// File: rtl/mash_datapath.sv
module mash_datapath
  import mash_pkg::*;
#(
  parameter int INT_W  = 12,
  parameter int FRAC_W = 32,
  parameter int STAGES = 4,
  parameter int ORD_W  = $clog2(STAGES),
  parameter int OUT_W  = INT_W + 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  mash_strb_t              strb,
  input  logic [INT_W-1:0]        cfgInt,
  input  logic [FRAC_W-1:0]       cfgNum,
  input  logic [FRAC_W-1:0]       cfgDen,
  input  logic [ORD_W-1:0]        cfgOrd,
  output logic signed [OUT_W-1:0] divOut,
  output logic                    divValid
);

  localparam int ACC_W    = FRAC_W + 1;       // holds sum of two values below 2^FRAC_W
  localparam int CW       = STAGES + 1;       // signed correction width
  localparam int CORR_MAX = 1 << (STAGES - 1);
  localparam int CORR_MIN = 1 - CORR_MAX;

  logic [ACC_W-1:0]        denExt;
  logic [ACC_W-1:0]        acc      [STAGES];
  logic [ACC_W-1:0]        stageIn  [STAGES];
  logic [ACC_W-1:0]        stageSum [STAGES];
  logic [ACC_W-1:0]        stageNxt [STAGES];
  logic [STAGES-1:0]       carry;
  logic [STAGES-1:0]       cEff;
  logic signed [CW-1:0]    tSum     [STAGES];
  logic signed [CW-1:0]    tDly     [1:STAGES-1];
  logic signed [OUT_W-1:0] corrExt;
  logic signed [OUT_W-1:0] intExt;

  assign denExt = {1'b0, cfgDen};

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    // Input chain: stage 1 takes the numerator, later stages take the
    // residue just produced by the stage before them.
    if (k == 0) begin : g_head
      assign stageIn[k] = {1'b0, cfgNum};
    end else begin : g_chain
      assign stageIn[k] = stageNxt[k-1];
    end

    assign stageSum[k] = acc[k] + stageIn[k];
    assign carry[k]    = (stageSum[k] >= denExt);
    assign stageNxt[k] = carry[k] ? (stageSum[k] - denExt) : stageSum[k];
    assign cEff[k]     = carry[k] & ~strb.fracOff & (ORD_W'(k) <= cfgOrd);

    // Nested differencing: t_k = c_k + t_{k+1} - t_{k+1}(previous step)
    if (k == STAGES - 1) begin : g_top
      assign tSum[k] = {{(CW-1){1'b0}}, cEff[k]};
    end else begin : g_diff
      assign tSum[k] = {{(CW-1){1'b0}}, cEff[k]} + tSum[k+1] - tDly[k+1];
    end

    always_ff @(posedge clk) begin
      if (rst || strb.clr) begin
        acc[k] <= '0;
      end else if (strb.step) begin
        acc[k] <= strb.fracOff ? '0 : stageNxt[k];
      end
    end

    if (k > 0) begin : g_hist
      always_ff @(posedge clk) begin
        if (rst || strb.clr) begin
          tDly[k] <= '0;
        end else if (strb.step) begin
          tDly[k] <= tSum[k];
        end
      end
    end

    // R3: every residue stays below the modulus once a valid setting is held
    a_r3_residue_below_den: assert property (@(posedge clk) disable iff (rst)
      !strb.fracOff |-> (acc[k] < denExt));
  end

  assign corrExt = {{(OUT_W-CW){tSum[0][CW-1]}}, tSum[0]};
  assign intExt  = {{(OUT_W-INT_W){1'b0}}, cfgInt};

  always_ff @(posedge clk) begin
    if (rst) begin
      divOut   <= '0;
      divValid <= 1'b0;
    end else if (strb.clr) begin
      divValid <= 1'b0;
    end else if (strb.step) begin
      divOut   <= intExt + corrExt;
      divValid <= 1'b1;
    end else begin
      divValid <= 1'b0;
    end
  end

  // R4 / R8: correction bounded by the fourth-order range
  a_r4_corr_range: assert property (@(posedge clk) disable iff (rst)
    strb.step |-> (tSum[0] >= CORR_MIN && tSum[0] <= CORR_MAX));

  // R6: rejected setting contributes nothing
  a_r6_frac_off_zero: assert property (@(posedge clk) disable iff (rst)
    strb.fracOff |-> (tSum[0] == 0));

  // R7: idle cycle freezes state and output
  a_r7_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!strb.step && !strb.clr) |=> ($stable(acc[0]) && $stable(divOut) && !divValid));

  // R2: load clears the first accumulator and the strobe
  a_r2_load_clears: assert property (@(posedge clk) disable iff (rst)
    strb.clr |=> (acc[0] == '0 && !divValid));

endmodule

// File: rtl/mash_frac_divider.sv
module mash_frac_divider
  import mash_pkg::*;
#(
  parameter int INT_W  = 12,
  parameter int FRAC_W = 32,
  parameter int STAGES = 4,
  parameter int ORD_W  = $clog2(STAGES),
  parameter int OUT_W  = INT_W + 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    load,
  input  logic                    enable,
  input  logic [INT_W-1:0]        intIn,
  input  logic [FRAC_W-1:0]       numIn,
  input  logic [FRAC_W-1:0]       denIn,
  input  logic [ORD_W-1:0]        orderSel,
  output logic signed [OUT_W-1:0] divOut,
  output logic                    divValid,
  output logic                    cfgErr
);

  mash_strb_t        strb;
  logic [INT_W-1:0]  cfgInt;
  logic [FRAC_W-1:0] cfgNum;
  logic [FRAC_W-1:0] cfgDen;
  logic [ORD_W-1:0]  cfgOrd;

  mash_ctrl #(.INT_W(INT_W), .FRAC_W(FRAC_W), .ORD_W(ORD_W)) u_ctrl (
    .clk(clk), .rst(rst), .load(load), .enable(enable),
    .intIn(intIn), .numIn(numIn), .denIn(denIn), .orderSel(orderSel),
    .cfgInt(cfgInt), .cfgNum(cfgNum), .cfgDen(cfgDen), .cfgOrd(cfgOrd),
    .cfgErr(cfgErr), .strb(strb)
  );

  mash_datapath #(.INT_W(INT_W), .FRAC_W(FRAC_W), .STAGES(STAGES),
                  .ORD_W(ORD_W), .OUT_W(OUT_W)) u_dp (
    .clk(clk), .rst(rst), .strb(strb),
    .cfgInt(cfgInt), .cfgNum(cfgNum), .cfgDen(cfgDen), .cfgOrd(cfgOrd),
    .divOut(divOut), .divValid(divValid)
  );

  // R1: reset clears the visible outputs
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (!divValid && divOut == '0 && !cfgErr));

  // R9: a step is followed by a valid strobe
  a_r9_valid_after_step: assert property (@(posedge clk) disable iff (rst)
    (enable && !load) |=> divValid);

  // R5: zero numerator gives the pure integer part
  a_r5_integer_mode: assert property (@(posedge clk) disable iff (rst)
    (divValid && cfgNum == '0) |-> (divOut == $signed({{(OUT_W-INT_W){1'b0}}, cfgInt})));

endmodule

// File: tb/tb_mash_frac_divider.sv
module tb_mash_frac_divider;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst, load, enable;
  logic [11:0] intIn;
  logic [31:0] numIn, denIn;
  logic [1:0]  orderSel;
  logic signed [13:0] divOut;
  logic divValid, cfgErr;

  int nChk = 0, nFail = 0;

  // Reference model state
  longint mInt, mNum, mDen;
  int     mOrd;
  bit     mErr;
  longint macc [4];
  bit     hc [4][3];

  always #(CLK_PERIOD/2) clk = ~clk;

  mash_frac_divider dut (
    .clk(clk), .rst(rst), .load(load), .enable(enable),
    .intIn(intIn), .numIn(numIn), .denIn(denIn), .orderSel(orderSel),
    .divOut(divOut), .divValid(divValid), .cfgErr(cfgErr)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic modelClear();
    for (int k = 0; k < 4; k++) begin
      macc[k] = 0;
      for (int j = 0; j < 3; j++) hc[k][j] = 1'b0;
    end
  endtask

  task automatic modelStep(output longint res);
    longint inV = mNum;
    bit c [4];
    longint y;
    for (int k = 0; k < 4; k++) begin
      longint s = macc[k] + inV;
      c[k] = (s >= mDen);
      if (c[k]) s = s - mDen;
      if (!mErr) macc[k] = s;
      inV = s;
      c[k] = c[k] && (k <= mOrd) && !mErr;
    end
    y = longint'(c[0])
      + longint'(c[1]) - longint'(hc[1][0])
      + longint'(c[2]) - 2*longint'(hc[2][0]) + longint'(hc[2][1])
      + longint'(c[3]) - 3*longint'(hc[3][0]) + 3*longint'(hc[3][1]) - longint'(hc[3][2]);
    for (int k = 0; k < 4; k++) begin
      hc[k][2] = hc[k][1];
      hc[k][1] = hc[k][0];
      hc[k][0] = c[k];
    end
    res = mInt + y;
  endtask

  // Called at a negedge; returns at the following negedge.
  task automatic doLoad(input int i, input longint n, input longint d, input int o);
    intIn = 12'(i); numIn = 32'(n); denIn = 32'(d); orderSel = 2'(o);
    load = 1'b1; enable = 1'b1;
    @(negedge clk);
    load = 1'b0;
    mInt = i; mNum = n; mDen = d; mOrd = o; mErr = (n >= d);
    modelClear();
    chk(divValid == 1'b0, "R2 valid low after load", longint'(divValid), 0);
    chk(cfgErr == mErr, "R6 error flag", longint'(cfgErr), longint'(mErr));
  endtask

  task automatic runN(input int n, input string req, output longint sum);
    longint exp;
    sum = 0;
    for (int c = 0; c < n; c++) begin
      enable = 1'b1; load = 1'b0;
      @(negedge clk);
      modelStep(exp);
      chk(divValid == 1'b1, "R9 valid after step", longint'(divValid), 1);
      chk(longint'(divOut) == exp, req, longint'(divOut), exp);
      sum += longint'(divOut);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end

  initial begin
    longint sum, held;
    void'($urandom(32'd4242));
    rst = 1'b1; load = 1'b0; enable = 1'b0;
    intIn = '0; numIn = '0; denIn = 32'd1; orderSel = '0;
    repeat (3) @(negedge clk);
    chk(divValid == 1'b0, "R1 reset valid", longint'(divValid), 0);
    chk(divOut == 0, "R1 reset divOut", longint'(divOut), 0);
    chk(cfgErr == 1'b0, "R1 reset cfgErr", longint'(cfgErr), 0);
    rst = 1'b0;

    // R3: order 1 exact average
    doLoad(100, 3, 7, 0);
    runN(21, "R3 order1 sequence", sum);
    chk(sum == 100*21 + 3*3, "R3 order1 average", sum, 100*21 + 3*3);
    doLoad(2000, 999, 1000, 0);
    runN(2000, "R3 order1 sequence", sum);
    chk(sum == 2000*2000 + 999*2, "R3 order1 average", sum, 2000*2000 + 999*2);

    // R4: higher orders against the model
    for (int o = 1; o < 4; o++) begin
      doLoad(500, 37, 101, o);
      runN(303, "R4 cascaded sequence", sum);
    end
    doLoad(1234, 64'h8000_0001, 64'hFFFF_FFFF, 3);
    runN(200, "R4 large modulus", sum);

    // R5: integer mode
    doLoad(777, 0, 12345, 3);
    runN(50, "R5 zero numerator", sum);
    chk(sum == 777*50, "R5 integer sum", sum, 777*50);

    // R6: rejected settings
    doLoad(300, 50, 50, 3);
    runN(30, "R6 num equal den", sum);
    chk(sum == 300*30, "R6 integer sum", sum, 300*30);
    doLoad(301, 5, 0, 2);
    runN(10, "R6 zero modulus", sum);

    // R8: extremes without wrap
    doLoad(4095, 511, 1000, 3);
    runN(1000, "R8 top integer", sum);
    doLoad(0, 489, 1000, 3);
    runN(1000, "R8 zero integer", sum);

    // R2: inputs change without load: output follows captured setting
    doLoad(900, 11, 29, 1);
    runN(10, "R2 before change", sum);
    intIn = 12'd5; numIn = 32'd1; denIn = 32'd2; orderSel = 2'd3;
    runN(40, "R2 ignored inputs", sum);
    chk(cfgErr == 1'b0, "R2 flag unchanged", longint'(cfgErr), 0);

    // R7: pause and resume
    doLoad(640, 17, 53, 3);
    runN(20, "R7 before pause", sum);
    held = longint'(divOut);
    enable = 1'b0;
    for (int p = 0; p < 5; p++) begin
      @(negedge clk);
      chk(divValid == 1'b0, "R7 valid low while idle", longint'(divValid), 0);
      chk(longint'(divOut) == held, "R7 output held", longint'(divOut), held);
    end
    runN(60, "R7 resume sequence", sum);

    // Random trials
    for (int t = 0; t < 24; t++) begin
      int o = int'($urandom % 4);
      int i = int'($urandom % 4096);
      longint d = longint'($urandom % 200) + 1;
      longint n = longint'($urandom) % d;
      doLoad(i, n, d, o);
      runN(int'(2*d), (o == 0) ? "R3 random order1" : "R4 random cascade", sum);
      if (o == 0)
        chk(sum == longint'(i)*2*d + 2*n, "R3 random average", sum, longint'(i)*2*d + 2*n);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end
endmodule